// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every processor bus cycle and raises a break request when a programmed condition matches. It has two comparison channels. Each channel compares the cycle address against its own address register and checks the cycle kind (instruction fetch, data read, data write) and the operand size against its own condition register. The second channel can also compare the bus data against a data register, under a per-bit mask. The mask uses a 1 to exclude a bit from the comparison.

A control register selects how the channels work together. In independent mode either channel breaks on its own. In sequential mode a break needs a channel B match that comes after an earlier channel A match. The control register also selects the break timing of each channel, enables the data term of channel B and holds a debug-enable bit. Two sticky match flags record channel hits until software clears them.

The break request is a registered one-cycle pulse. It comes with an indication of whether the break is taken after execution. Registers are accessed through a simple write strobe, a 3-bit selector and a registered read-data port.

Top module: `bbk_top`

## Requirements
- R1: A synchronous reset clears every register, both match flags, the sequential armed state, `brk_req`, `brk_after` and `reg_rdata`.
- R2: Channel A hits when `bus_valid` is high, the address equals the A address register (selector 0), and the cycle kind is enabled in the A condition register (selector 1). The kind enables are bit 0 fetch, bit 1 data read and bit 2 data write. The size code in bits 4:3 must be 0 (any) or equal `bus_size`+1, where `bus_size` is 0 byte, 1 word, 2 long. In independent mode a hit gives `brk_req`=1 on the cycle after the bus cycle.
- R3: Channel B uses the same rules with its address register (selector 2) and its condition register (selector 3). When the data term is off, channel B breaks on its own in independent mode.
- R4: With the data-enable bit (control bit 7) set and a long size code, channel B also needs `(bus_data ^ data) & ~mask` to be zero. The data register is selector 4 and the mask register is selector 5.
- R5: With the data term on, a byte size code matches when either bits 7:0 or bits 15:8 agree under the mask. A word size code compares bits 15:0.
- R6: With the data term on and size code 0, channel B never matches.
- R7: Sequential mode (control bit 3) works as follows:
  - A channel A hit arms the channels and does not break.
  - A channel B hit breaks only if the channels were armed before that cycle.
  - A break disarms the channels, unless channel A hits in the same cycle.
- R8: Clearing the sequential bit drops the armed state.
- R9: `brk_after` follows the channel that caused the break:
  - for a fetch, it equals that channel's timing bit (A bit 10, B bit 6), where 1 means after execution;
  - for a data access, it is 1;
  - in sequential mode channel B decides;
  - in independent mode channel A has priority when both channels hit.
- R10: Match flags (A bit 15, B bit 14) are set by a channel hit. A control write of 0 clears a flag and a write of 1 leaves it as it is. A hit in the same cycle as a clearing write wins.
- R11: Control bits other than 15, 14, 10, 7, 6, 3 and 0 read as 0, and writes to them are ignored. Condition registers read back only bits 4:0.
- R12: `brk_req` is a one-cycle pulse for each qualifying bus cycle. Back-to-back qualifying cycles give back-to-back pulses, and no pulse appears without `bus_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register selector for write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data of the selected register |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_fetch | input | 1 | Cycle is an instruction fetch |
| bus_wr | input | 1 | Data cycle is a write (ignored for fetch) |
| bus_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| bus_addr | input | ADDR_W | Cycle address |
| bus_data | input | DATA_W | Cycle data |
| brk_req | output | 1 | One-cycle break request |
| brk_after | output | 1 | Break is taken after execution |

## Verification
A bus cycle that is sampled at a clock edge shows up on `brk_req`/`brk_after` at that same edge. The bench drives on the falling edge and reads the outputs on the next falling edge, which is exactly one cycle later. A match flag is set at the same edge, and a read that is selected on the following falling edge returns it one edge later. Register writes take effect at the edge that samples them, so every check samples one full cycle after the stimulus. The channel A condition space is swept in full, and the masked data compare is swept over many computed mask and data patterns.

// File: rtl/bbk_pkg.sv
package bbk_pkg;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_ADDR_A = 3'd0;
  localparam logic [SEL_W-1:0] SEL_COND_A = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR_B = 3'd2;
  localparam logic [SEL_W-1:0] SEL_COND_B = 3'd3;
  localparam logic [SEL_W-1:0] SEL_DATA_B = 3'd4;
  localparam logic [SEL_W-1:0] SEL_MASK_B = 3'd5;
  localparam logic [SEL_W-1:0] SEL_CTRL   = 3'd6;

  // control bit positions
  localparam int CB_FLAG_A = 15;
  localparam int CB_FLAG_B = 14;
  localparam int CB_TIME_A = 10;
  localparam int CB_DEN_B  = 7;
  localparam int CB_TIME_B = 6;
  localparam int CB_SEQ    = 3;
  localparam int CB_DBG    = 0;

  // size codes of a condition register
  localparam logic [1:0] SZC_ANY  = 2'd0;
  localparam logic [1:0] SZC_BYTE = 2'd1;
  localparam logic [1:0] SZC_WORD = 2'd2;
  localparam logic [1:0] SZC_LONG = 2'd3;

  typedef struct packed {
    logic [1:0] size;
    logic       en_wr;
    logic       en_rd;
    logic       en_fetch;
  } cond_t;

  typedef struct packed {
    logic flag_a;
    logic flag_b;
    logic time_a;
    logic den_b;
    logic time_b;
    logic seq;
    logic dbg;
  } ctrl_t;
endpackage

// File: rtl/bbk_regs.sv
module bbk_regs
  import bbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  input  logic              set_a,
  input  logic              set_b,
  output logic [ADDR_W-1:0] addr_a,
  output logic [ADDR_W-1:0] addr_b,
  output cond_t             cond_a,
  output cond_t             cond_b,
  output logic [DATA_W-1:0] data_b,
  output logic [DATA_W-1:0] mask_b,
  output ctrl_t             ctrl,
  output logic [DATA_W-1:0] rdata
);
  localparam int CW = $bits(cond_t);

  logic              we_ctrl;
  logic [DATA_W-1:0] rd_n;

  assign we_ctrl = we && (sel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_a <= '0;
      addr_b <= '0;
      cond_a <= '0;
      cond_b <= '0;
      data_b <= '0;
      mask_b <= '0;
      ctrl   <= '0;
    end else begin
      if (we) begin
        case (sel)
          SEL_ADDR_A: addr_a <= wdata[ADDR_W-1:0];
          SEL_COND_A: cond_a <= wdata[CW-1:0];
          SEL_ADDR_B: addr_b <= wdata[ADDR_W-1:0];
          SEL_COND_B: cond_b <= wdata[CW-1:0];
          SEL_DATA_B: data_b <= wdata;
          SEL_MASK_B: mask_b <= wdata;
          SEL_CTRL: begin
            ctrl.time_a <= wdata[CB_TIME_A];
            ctrl.den_b  <= wdata[CB_DEN_B];
            ctrl.time_b <= wdata[CB_TIME_B];
            ctrl.seq    <= wdata[CB_SEQ];
            ctrl.dbg    <= wdata[CB_DBG];
          end
          default: ;
        endcase
      end
      // write 0 clears, hardware set has priority
      ctrl.flag_a <= (ctrl.flag_a && !(we_ctrl && !wdata[CB_FLAG_A])) || set_a;
      ctrl.flag_b <= (ctrl.flag_b && !(we_ctrl && !wdata[CB_FLAG_B])) || set_b;
    end
  end

  always_comb begin
    rd_n = '0;
    case (sel)
      SEL_ADDR_A: rd_n[ADDR_W-1:0] = addr_a;
      SEL_COND_A: rd_n[CW-1:0]     = cond_a;
      SEL_ADDR_B: rd_n[ADDR_W-1:0] = addr_b;
      SEL_COND_B: rd_n[CW-1:0]     = cond_b;
      SEL_DATA_B: rd_n             = data_b;
      SEL_MASK_B: rd_n             = mask_b;
      SEL_CTRL: begin
        rd_n[CB_FLAG_A] = ctrl.flag_a;
        rd_n[CB_FLAG_B] = ctrl.flag_b;
        rd_n[CB_TIME_A] = ctrl.time_a;
        rd_n[CB_DEN_B]  = ctrl.den_b;
        rd_n[CB_TIME_B] = ctrl.time_b;
        rd_n[CB_SEQ]    = ctrl.seq;
        rd_n[CB_DBG]    = ctrl.dbg;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_n;
  end
endmodule

// File: rtl/bbk_dmatch.sv
module bbk_dmatch
  import bbk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              enable,
  input  logic [1:0]        size_code,
  input  logic [DATA_W-1:0] bus_data,
  input  logic [DATA_W-1:0] value,
  input  logic [DATA_W-1:0] mask,
  output logic              ok
);
  localparam int LANE = 8;

  logic [DATA_W-1:0] diff;
  logic              lane0_ok, lane1_ok, half_ok, full_ok;

  assign diff     = (bus_data ^ value) & ~mask;
  assign lane0_ok = (diff[LANE-1:0] == '0);
  assign lane1_ok = (diff[2*LANE-1:LANE] == '0);
  assign half_ok  = lane0_ok && lane1_ok;
  assign full_ok  = (diff == '0);

  always_comb begin
    if (!enable) ok = 1'b1;
    else begin
      case (size_code)
        SZC_BYTE: ok = lane0_ok || lane1_ok;
        SZC_WORD: ok = half_ok;
        SZC_LONG: ok = full_ok;
        default:  ok = 1'b0;   // no operand size: data term invalid
      endcase
    end
  end
endmodule

// File: rtl/bbk_chan.sv
module bbk_chan
  import bbk_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic              fetch,
  input  logic              wr,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] ref_addr,
  input  cond_t             cond,
  input  logic              data_ok,
  output logic              hit
);
  logic kind_ok, size_ok;

  always_comb begin
    if (fetch)   kind_ok = cond.en_fetch;
    else if (wr) kind_ok = cond.en_wr;
    else         kind_ok = cond.en_rd;
  end

  assign size_ok = (cond.size == SZC_ANY) || (cond.size == (size + 2'd1));
  assign hit     = valid && (addr == ref_addr) && kind_ok && size_ok && data_ok;
endmodule

// File: rtl/bbk_seq.sv
module bbk_seq (
  input  logic clk,
  input  logic rst,
  input  logic hit_a,
  input  logic hit_b,
  input  logic fetch,
  input  logic seq_on,
  input  logic time_a,
  input  logic time_b,
  output logic armed,
  output logic brk_req,
  output logic brk_after
);
  logic fire, after_n, tim_a, tim_b;

  assign tim_a = fetch ? time_a : 1'b1;
  assign tim_b = fetch ? time_b : 1'b1;

  always_comb begin
    if (seq_on) begin
      fire    = hit_b && armed;
      after_n = tim_b;
    end else begin
      fire    = hit_a || hit_b;
      after_n = hit_a ? tim_a : tim_b;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed     <= 1'b0;
      brk_req   <= 1'b0;
      brk_after <= 1'b0;
    end else begin
      brk_req   <= fire;
      brk_after <= fire && after_n;
      if (!seq_on)    armed <= 1'b0;
      else if (fire)  armed <= hit_a;
      else if (hit_a) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/bbk_top.sv
module bbk_top
  import bbk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              bus_valid,
  input  logic              bus_fetch,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  output logic              brk_req,
  output logic              brk_after
);
  logic [ADDR_W-1:0] addr_a, addr_b;
  cond_t             cond_a, cond_b;
  logic [DATA_W-1:0] data_b, mask_b;
  ctrl_t             ctrl;
  logic              hit_a, hit_b, data_ok_b, armed;
  logic              seq_on, flag_a, flag_b;

  assign seq_on = ctrl.seq;
  assign flag_a = ctrl.flag_a;
  assign flag_b = ctrl.flag_b;

  bbk_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .set_a(hit_a), .set_b(hit_b),
    .addr_a(addr_a), .addr_b(addr_b), .cond_a(cond_a), .cond_b(cond_b),
    .data_b(data_b), .mask_b(mask_b), .ctrl(ctrl), .rdata(reg_rdata)
  );

  bbk_dmatch #(.DATA_W(DATA_W)) u_dmatch_b (
    .enable(ctrl.den_b), .size_code(cond_b.size), .bus_data(bus_data),
    .value(data_b), .mask(mask_b), .ok(data_ok_b)
  );

  bbk_chan #(.ADDR_W(ADDR_W)) u_chan_a (
    .valid(bus_valid), .fetch(bus_fetch), .wr(bus_wr), .size(bus_size),
    .addr(bus_addr), .ref_addr(addr_a), .cond(cond_a), .data_ok(1'b1),
    .hit(hit_a)
  );

  bbk_chan #(.ADDR_W(ADDR_W)) u_chan_b (
    .valid(bus_valid), .fetch(bus_fetch), .wr(bus_wr), .size(bus_size),
    .addr(bus_addr), .ref_addr(addr_b), .cond(cond_b), .data_ok(data_ok_b),
    .hit(hit_b)
  );

  bbk_seq u_seq (
    .clk(clk), .rst(rst), .hit_a(hit_a), .hit_b(hit_b), .fetch(bus_fetch),
    .seq_on(seq_on), .time_a(ctrl.time_a), .time_b(ctrl.time_b),
    .armed(armed), .brk_req(brk_req), .brk_after(brk_after)
  );
endmodule

// File: rtl/bbk_checker.sv
module bbk_checker (
  input logic clk,
  input logic rst,
  input logic bus_valid,
  input logic bus_fetch,
  input logic hit_a,
  input logic hit_b,
  input logic seq_on,
  input logic armed,
  input logic flag_a,
  input logic flag_b,
  input logic brk_req,
  input logic brk_after
);
  p_req_needs_bus_r12: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> $past(bus_valid));

  p_indep_hit_breaks_r2: assert property (@(posedge clk) disable iff (rst)
    (!seq_on && hit_a) |=> brk_req);

  p_seq_needs_arm_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_on && !armed) |=> !brk_req);

  p_arm_drops_r8: assert property (@(posedge clk) disable iff (rst)
    !seq_on |=> !armed);

  p_data_after_r9: assert property (@(posedge clk) disable iff (rst)
    brk_req |-> (brk_after || $past(bus_fetch)));

  p_flag_a_set_r10: assert property (@(posedge clk) disable iff (rst)
    hit_a |=> flag_a);

  p_flag_b_set_r10: assert property (@(posedge clk) disable iff (rst)
    hit_b |=> flag_b);
endmodule

bind bbk_top bbk_checker u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_fetch(bus_fetch),
  .hit_a(hit_a), .hit_b(hit_b), .seq_on(seq_on), .armed(armed),
  .flag_a(flag_a), .flag_b(flag_b), .brk_req(brk_req), .brk_after(brk_after)
);

// File: tb/bbk_top_tb_top.sv
module bbk_top_tb_top;
  localparam logic [2:0] S_AA = 3'd0, S_CA = 3'd1, S_AB = 3'd2, S_CB = 3'd3,
                         S_DB = 3'd4, S_MB = 3'd5, S_CT = 3'd6;
  localparam logic [31:0] A_ADR = 32'h1000_0040;
  localparam logic [31:0] B_ADR = 32'h2000_0180;
  localparam logic [31:0] VAL   = 32'hA5C3_0F96;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        bus_valid = 1'b0, bus_fetch = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_size = '0;
  logic [31:0] bus_addr = '0, bus_data = '0;
  logic        brk_req, brk_after;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  bbk_top dut_i (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_valid(bus_valid),
    .bus_fetch(bus_fetch), .bus_wr(bus_wr), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_data(bus_data), .brk_req(brk_req),
    .brk_after(brk_after)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    reg_we = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    reg_sel = s;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic cyc(input logic f, input logic w, input logic [1:0] sz,
                     input logic [31:0] a, input logic [31:0] d,
                     output logic rq, output logic af);
    bus_valid = 1'b1; bus_fetch = f; bus_wr = w; bus_size = sz;
    bus_addr = a; bus_data = d;
    @(negedge clk);
    rq = brk_req; af = brk_after;
    bus_valid = 1'b0;
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] v, lf, msk, flip, d;
    logic rq, af, e;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1 req", {31'd0, brk_req}, 32'd0);
    chk("R1 after", {31'd0, brk_after}, 32'd0);
    rd(S_CT, v); chk("R1 ctrl", v, 32'd0);
    rd(S_MB, v); chk("R1 mask", v, 32'd0);

    // R11: reserved bits
    wr(S_CT, 32'hFFFF_FFFF);
    rd(S_CT, v); chk("R11 ctrl readback (R10 write-1 no set)", v, 32'h0000_04C9);
    wr(S_CA, 32'hFFFF_FFFF);
    rd(S_CA, v); chk("R11 cond readback", v, 32'h0000_001F);
    wr(S_CT, 32'h0);

    // R2: full sweep of channel A condition space
    wr(S_AB, B_ADR); wr(S_CB, 32'h0); wr(S_AA, A_ADR);
    for (int cm = 0; cm < 8; cm++) begin
      for (int sc = 0; sc < 4; sc++) begin
        wr(S_CA, 32'(sc * 8 + cm));
        for (int k = 0; k < 3; k++) begin
          for (int sz = 0; sz < 3; sz++) begin
            for (int m = 0; m < 2; m++) begin
              cyc(k == 0, k == 2, 2'(sz), (m == 1) ? A_ADR : (A_ADR ^ 32'h4), 32'h0, rq, af);
              e = (m == 1) && cm[k] && (sc == 0 || sc == sz + 1);
              chk("R2 chanA", {31'd0, rq}, {31'd0, e});
              if (e) chk("R9 timing", {31'd0, af}, (k == 0) ? 32'd0 : 32'd1);
            end
          end
        end
      end
    end

    // R3: channel B alone, no data term
    wr(S_CA, 32'h0);
    for (int cm = 0; cm < 8; cm++) begin
      wr(S_CB, 32'(cm));
      for (int k = 0; k < 3; k++) begin
        cyc(k == 0, k == 2, 2'd2, B_ADR, 32'h0, rq, af);
        chk("R3 chanB", {31'd0, rq}, {31'd0, cm[k]});
      end
    end

    // R4: masked long compare
    wr(S_CT, 32'h80); wr(S_CB, 32'h1A); wr(S_DB, VAL);
    lf = 32'h1234_5678;
    for (int i = 0; i < 64; i++) begin
      lf = xs(lf); msk = lf;
      wr(S_MB, msk);
      lf = xs(lf);
      flip = (i % 2 == 1) ? (lf & msk) : ((i % 8 == 0) ? 32'h0 : lf);
      d = VAL ^ flip;
      cyc(1'b0, 1'b0, 2'd2, B_ADR, d, rq, af);
      e = (((d ^ VAL) & ~msk) == 32'h0);
      chk("R4 masked data", {31'd0, rq}, {31'd0, e});
      if (e) chk("R9 data after", {31'd0, af}, 32'd1);
    end

    // R5: byte lanes and word
    wr(S_MB, 32'h0); wr(S_DB, 32'h0000_5A3C); wr(S_CB, 32'h0A);
    cyc(1'b0, 1'b0, 2'd0, B_ADR, 32'h1111_223C, rq, af); chk("R5 byte lane0", {31'd0, rq}, 32'd1);
    cyc(1'b0, 1'b0, 2'd0, B_ADR, 32'h0000_5A00, rq, af); chk("R5 byte lane1", {31'd0, rq}, 32'd1);
    cyc(1'b0, 1'b0, 2'd0, B_ADR, 32'h0000_3C5A, rq, af); chk("R5 byte swapped", {31'd0, rq}, 32'd0);
    cyc(1'b0, 1'b0, 2'd0, B_ADR, 32'h5A3C_0000, rq, af); chk("R5 byte upper", {31'd0, rq}, 32'd0);
    wr(S_MB, 32'h0000_0F0F);
    cyc(1'b0, 1'b0, 2'd0, B_ADR, 32'h0000_0035, rq, af); chk("R5 byte masked", {31'd0, rq}, 32'd1);
    wr(S_MB, 32'h0); wr(S_CB, 32'h12);
    cyc(1'b0, 1'b0, 2'd1, B_ADR, 32'hFFFF_5A3C, rq, af); chk("R5 word", {31'd0, rq}, 32'd1);
    cyc(1'b0, 1'b0, 2'd1, B_ADR, 32'h0000_5A3D, rq, af); chk("R5 word miss", {31'd0, rq}, 32'd0);

    // R6: data term without size
    wr(S_CB, 32'h02); wr(S_DB, VAL);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, VAL, rq, af); chk("R6 no size", {31'd0, rq}, 32'd0);
    wr(S_CT, 32'h0);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, VAL, rq, af); chk("R6 data off", {31'd0, rq}, 32'd1);

    // R7: sequential
    wr(S_CT, 32'h08); wr(S_AA, A_ADR); wr(S_CA, 32'h01);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af); chk("R7 B first", {31'd0, rq}, 32'd0);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R7 A arms", {31'd0, rq}, 32'd0);
    @(negedge clk);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af); chk("R7 A then B", {31'd0, rq}, 32'd1);
    chk("R9 seq data after", {31'd0, af}, 32'd1);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af); chk("R7 disarmed", {31'd0, rq}, 32'd0);
    wr(S_AB, A_ADR); wr(S_CB, 32'h01);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R7 same cycle", {31'd0, rq}, 32'd0);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R7 rearm fire", {31'd0, rq}, 32'd1);
    chk("R9 seq uses B timing", {31'd0, af}, 32'd0);
    wr(S_CT, 32'h48);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R7 fire again", {31'd0, rq}, 32'd1);
    chk("R9 seq B after", {31'd0, af}, 32'd1);

    // R8: clearing sequential mode drops the armed state
    wr(S_AB, B_ADR); wr(S_CB, 32'h02); wr(S_CT, 32'h08);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af);
    wr(S_CT, 32'h0); wr(S_CT, 32'h08);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af); chk("R8 disarmed", {31'd0, rq}, 32'd0);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af); chk("R8 rearmed", {31'd0, rq}, 32'd1);

    // R9: independent priority
    wr(S_AB, A_ADR); wr(S_CB, 32'h01); wr(S_CT, 32'h40);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af);
    chk("R9 both req", {31'd0, rq}, 32'd1); chk("R9 A priority", {31'd0, af}, 32'd0);
    wr(S_CT, 32'h400);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R9 A after", {31'd0, af}, 32'd1);
    wr(S_AA, B_ADR); wr(S_CT, 32'h40);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R9 B only after", {31'd0, af}, 32'd1);
    wr(S_CT, 32'h0);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af); chk("R9 B only before", {31'd0, af}, 32'd0);

    // R10: sticky flags
    wr(S_AA, A_ADR); wr(S_AB, B_ADR); wr(S_CB, 32'h02); wr(S_CT, 32'h0);
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af);
    rd(S_CT, v); chk("R10 flag A set", v, 32'h0000_8000);
    wr(S_CT, 32'h0000_C000);
    rd(S_CT, v); chk("R10 write 1 keeps", v, 32'h0000_8000);
    wr(S_CT, 32'h0);
    rd(S_CT, v); chk("R10 write 0 clears", v, 32'h0);
    reg_we = 1'b1; reg_sel = S_CT; reg_wdata = 32'h0;
    cyc(1'b1, 1'b0, 2'd2, A_ADR, 32'h0, rq, af);
    reg_we = 1'b0;
    rd(S_CT, v); chk("R10 set wins", v, 32'h0000_8000);
    cyc(1'b0, 1'b0, 2'd2, B_ADR, 32'h0, rq, af);
    rd(S_CT, v); chk("R10 flag B set", v, 32'h0000_C000);
    wr(S_CT, 32'h0000_4000);
    rd(S_CT, v); chk("R10 clear A only", v, 32'h0000_4000);

    // R12: pulses
    bus_valid = 1'b1; bus_fetch = 1'b1; bus_wr = 1'b0; bus_size = 2'd2; bus_addr = A_ADR;
    @(negedge clk); chk("R12 pulse 1", {31'd0, brk_req}, 32'd1);
    @(negedge clk); chk("R12 pulse 2", {31'd0, brk_req}, 32'd1);
    bus_valid = 1'b0;
    @(negedge clk); chk("R12 no valid", {31'd0, brk_req}, 32'd0);
    @(negedge clk); chk("R12 stays low", {31'd0, brk_req}, 32'd0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule